// File: doc/BRIEF.md
# Way-Group Pending Counter Array

This block holds one small counter for each way group of a coherence controller. A counter counts the open work for a transaction on a group of related addresses. It goes up when the controller starts on a new request for that group, and again for every command the controller sends to memory for it. It goes down for every memory response the controller processes and for every acknowledgement a cache returns. A transaction is finished only when its counter is back at zero.

Before it begins a new request, the controller reads the pending flag of the target group. A nonzero counter means that older work on related addresses is still in flight. Because each group has its own counter, the controller can move on to unrelated requests while memory or caches are still answering older ones. Microcode can also load a counter with a chosen value and clear it.

All event ports can name the same group in the same cycle without losing an event. Counters stop at their limits instead of wrapping, and each kind of limit violation raises its own sticky error bit.

Top module: `pend_ctr_array`

## Requirements
- R1: After reset every counter reads 0, `rd_pending` is 0 and both error bits are 0.
- R2: A cycle with `start_vld` high adds one to the counter selected by `start_idx`.
- R3: A cycle with `mcmd_vld` high adds one to the counter selected by `mcmd_idx`.
- R4: A cycle with `mrsp_vld` high subtracts one from the counter selected by `mrsp_idx`. A cycle with `ack_vld` high subtracts one from the counter selected by `ack_idx`.
- R5: `rd_count` shows the counter selected by `rd_idx` without delay. `rd_pending` is 1 exactly when that counter is nonzero. Updates made at a clock edge become visible only after that edge, so a same-cycle update is not forwarded.
- R6: All increments and decrements aimed at one group in one cycle add up to a single net change. For example, start and memory command together add 2, and all four events together leave the counter unchanged.
- R7: When the net result would exceed 2^CNT_W-1 (15 by default), the counter holds at 15 and `err_ovf` becomes 1. `err_ovf` then stays 1 until reset.
- R8: When the net result would go below 0, the counter holds at 0 and `err_unf` becomes 1. `err_unf` then stays 1 until reset.
- R9: `wr_vld` loads `wr_data` into the counter selected by `wr_idx`.
- R10: `clr_vld` sets the counter selected by `clr_idx` to 0.
- R11: On one group, clear takes priority over write, and write takes priority over events. Events that lose to a clear or a write are dropped and never raise an error bit.
- R12: Any update leaves every counter it does not select unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_vld | input | 1 | New request begins |
| start_idx | input | IDX_W | Group of the new request |
| mcmd_vld | input | 1 | Memory command sent |
| mcmd_idx | input | IDX_W | Group of the memory command |
| mrsp_vld | input | 1 | Memory response processed |
| mrsp_idx | input | IDX_W | Group of the memory response |
| ack_vld | input | 1 | Coherence acknowledgement received |
| ack_idx | input | IDX_W | Group of the acknowledgement |
| wr_vld | input | 1 | Microcode write |
| wr_idx | input | IDX_W | Group to write |
| wr_data | input | CNT_W | Value to write |
| clr_vld | input | 1 | Microcode clear |
| clr_idx | input | IDX_W | Group to clear |
| rd_idx | input | IDX_W | Group to read |
| rd_count | output | CNT_W | Counter of the read group |
| rd_pending | output | 1 | Read group counter is nonzero |
| err_ovf | output | 1 | Sticky saturation-at-top error |
| err_unf | output | 1 | Sticky saturation-at-zero error |

## Verification
The hardest situations to reach are the ones where several sources name one group in the same cycle. These include four events whose effects cancel, an event that pushes a counter past a limit in a cycle that also carries an opposite event, and events that lose to a clear or a write. The directed tasks drive these overlaps on purpose: they first load a chosen counter value with a write, then pulse the colliding inputs in a single cycle. Each task then checks the resulting count and the error bits.

// File: rtl/pend_ctr_array.sv
module pend_ctr_array #(
  parameter int NUM_GRP = 64,
  parameter int CNT_W   = 4,
  localparam int IDX_W  = $clog2(NUM_GRP)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_vld,
  input  logic [IDX_W-1:0] start_idx,
  input  logic             mcmd_vld,
  input  logic [IDX_W-1:0] mcmd_idx,
  input  logic             mrsp_vld,
  input  logic [IDX_W-1:0] mrsp_idx,
  input  logic             ack_vld,
  input  logic [IDX_W-1:0] ack_idx,
  input  logic             wr_vld,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             clr_vld,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CNT_W-1:0] rd_count,
  output logic             rd_pending,
  output logic             err_ovf,
  output logic             err_unf
);
  localparam int SUM_W = CNT_W + 2;
  localparam logic [SUM_W-1:0] MAXV = SUM_W'((1 << CNT_W) - 1);

  logic [CNT_W-1:0] cnt_q [NUM_GRP];
  logic [NUM_GRP-1:0] ovf_vec, unf_vec;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_ent
    logic hit_st, hit_mc, hit_mr, hit_ak, hit_wr, hit_cl;
    logic [1:0] up, dn;
    logic [SUM_W-1:0] sum, res;
    logic [CNT_W-1:0] nxt;
    logic ovf, unf;

    assign hit_st = start_vld && start_idx == IDX_W'(g);
    assign hit_mc = mcmd_vld  && mcmd_idx  == IDX_W'(g);
    assign hit_mr = mrsp_vld  && mrsp_idx  == IDX_W'(g);
    assign hit_ak = ack_vld   && ack_idx   == IDX_W'(g);
    assign hit_wr = wr_vld    && wr_idx    == IDX_W'(g);
    assign hit_cl = clr_vld   && clr_idx   == IDX_W'(g);

    assign up  = {1'b0, hit_st} + {1'b0, hit_mc};
    assign dn  = {1'b0, hit_mr} + {1'b0, hit_ak};
    assign sum = {2'b00, cnt_q[g]} + {{(SUM_W-2){1'b0}}, up};
    assign unf = !hit_cl && !hit_wr && (sum < {{(SUM_W-2){1'b0}}, dn});
    assign res = unf ? '0 : sum - {{(SUM_W-2){1'b0}}, dn};
    assign ovf = !hit_cl && !hit_wr && (res > MAXV);

    always_comb begin
      if (hit_cl)      nxt = '0;
      else if (hit_wr) nxt = wr_data;
      else if (ovf)    nxt = MAXV[CNT_W-1:0];
      else             nxt = res[CNT_W-1:0];
    end

    assign ovf_vec[g] = ovf;
    assign unf_vec[g] = unf;

    always_ff @(posedge clk) begin
      if (!rst_n) cnt_q[g] <= '0;
      else        cnt_q[g] <= nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_ovf <= 1'b0;
      err_unf <= 1'b0;
    end else begin
      err_ovf <= err_ovf | (|ovf_vec);
      err_unf <= err_unf | (|unf_vec);
    end
  end

  assign rd_count   = cnt_q[rd_idx];
  assign rd_pending = |rd_count;
endmodule

module pend_ctr_array_chk #(
  parameter int NUM_GRP = 64,
  parameter int CNT_W   = 4,
  localparam int IDX_W  = $clog2(NUM_GRP)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_vld,
  input logic [IDX_W-1:0] start_idx,
  input logic             mcmd_vld,
  input logic [IDX_W-1:0] mcmd_idx,
  input logic             mrsp_vld,
  input logic [IDX_W-1:0] mrsp_idx,
  input logic             ack_vld,
  input logic [IDX_W-1:0] ack_idx,
  input logic             wr_vld,
  input logic [IDX_W-1:0] wr_idx,
  input logic [CNT_W-1:0] wr_data,
  input logic             clr_vld,
  input logic [IDX_W-1:0] clr_idx,
  input logic [IDX_W-1:0] rd_idx,
  input logic [CNT_W-1:0] rd_count,
  input logic             rd_pending,
  input logic             err_ovf,
  input logic             err_unf
);
  localparam logic [CNT_W-1:0] TOP = '1;
  logic h_st, h_mc, h_mr, h_ak, h_wr, h_cl, none;
  assign h_st = start_vld && start_idx == rd_idx;
  assign h_mc = mcmd_vld  && mcmd_idx  == rd_idx;
  assign h_mr = mrsp_vld  && mrsp_idx  == rd_idx;
  assign h_ak = ack_vld   && ack_idx   == rd_idx;
  assign h_wr = wr_vld    && wr_idx    == rd_idx;
  assign h_cl = clr_vld   && clr_idx   == rd_idx;
  assign none = !(h_st || h_mc || h_mr || h_ak || h_wr || h_cl);

  AST_START_INC: assert property (@(posedge clk) disable iff (!rst_n)
    h_st && !h_mc && !h_mr && !h_ak && !h_wr && !h_cl && rd_count != TOP
    |=> rd_idx != $past(rd_idx) || rd_count == $past(rd_count) + 1'b1); // R2
  AST_MCMD_INC: assert property (@(posedge clk) disable iff (!rst_n)
    h_mc && !h_st && !h_mr && !h_ak && !h_wr && !h_cl && rd_count != TOP
    |=> rd_idx != $past(rd_idx) || rd_count == $past(rd_count) + 1'b1); // R3
  AST_RESP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    h_mr && !h_st && !h_mc && !h_ak && !h_wr && !h_cl && rd_count != '0
    |=> rd_idx != $past(rd_idx) || rd_count == $past(rd_count) - 1'b1); // R4
  AST_PEND_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pending == (rd_count != '0)); // R5
  AST_SAT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    h_st && !h_mr && !h_ak && !h_wr && !h_cl && rd_count == TOP
    |=> err_ovf && (rd_idx != $past(rd_idx) || rd_count == TOP)); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_ovf |=> err_ovf); // R7
  AST_FLOOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    h_ak && !h_st && !h_mc && !h_wr && !h_cl && rd_count == '0
    |=> err_unf && (rd_idx != $past(rd_idx) || rd_count == '0)); // R8
  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_unf |=> err_unf); // R8
  AST_WR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    h_wr && !h_cl |=> rd_idx != $past(rd_idx) || rd_count == $past(wr_data)); // R9
  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    h_cl |=> rd_idx != $past(rd_idx) || rd_count == '0); // R11
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    none |=> rd_idx != $past(rd_idx) || $stable(rd_count)); // R12
endmodule

bind pend_ctr_array pend_ctr_array_chk #(.NUM_GRP(NUM_GRP), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .start_vld(start_vld), .start_idx(start_idx),
  .mcmd_vld(mcmd_vld), .mcmd_idx(mcmd_idx),
  .mrsp_vld(mrsp_vld), .mrsp_idx(mrsp_idx),
  .ack_vld(ack_vld), .ack_idx(ack_idx),
  .wr_vld(wr_vld), .wr_idx(wr_idx), .wr_data(wr_data),
  .clr_vld(clr_vld), .clr_idx(clr_idx),
  .rd_idx(rd_idx), .rd_count(rd_count), .rd_pending(rd_pending),
  .err_ovf(err_ovf), .err_unf(err_unf)
);

// File: tb/sim_pend_ctr_array.sv
`timescale 1ns/1ps
module sim_pend_ctr_array;
  localparam int NG = 64, CW = 4, IW = 6;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start_vld, mcmd_vld, mrsp_vld, ack_vld, wr_vld, clr_vld;
  logic [IW-1:0] start_idx, mcmd_idx, mrsp_idx, ack_idx, wr_idx, clr_idx, rd_idx;
  logic [CW-1:0] wr_data, rd_count;
  logic rd_pending, err_ovf, err_unf;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  pend_ctr_array #(.NUM_GRP(NG), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .start_vld(start_vld), .start_idx(start_idx),
    .mcmd_vld(mcmd_vld), .mcmd_idx(mcmd_idx),
    .mrsp_vld(mrsp_vld), .mrsp_idx(mrsp_idx),
    .ack_vld(ack_vld), .ack_idx(ack_idx),
    .wr_vld(wr_vld), .wr_idx(wr_idx), .wr_data(wr_data),
    .clr_vld(clr_vld), .clr_idx(clr_idx),
    .rd_idx(rd_idx), .rd_count(rd_count), .rd_pending(rd_pending),
    .err_ovf(err_ovf), .err_unf(err_unf));

  task automatic idle();
    {start_vld, mcmd_vld, mrsp_vld, ack_vld, wr_vld, clr_vld} = '0;
    {start_idx, mcmd_idx, mrsp_idx, ack_idx, wr_idx, clr_idx} = '0;
    wr_data = '0;
  endtask

  task automatic tick();
    @(posedge clk); #1; idle(); #1;
  endtask

  task automatic chk(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cnt_is(string req, int idx, int exp);
    rd_idx = IW'(idx); #1;
    chk(req, $sformatf("count[%0d]", idx), int'(rd_count), exp);
    chk(req, $sformatf("pending[%0d]", idx), int'(rd_pending), int'(exp != 0));
  endtask

  task automatic load(int idx, int val);
    wr_vld = 1'b1; wr_idx = IW'(idx); wr_data = CW'(val); tick();
  endtask

  task automatic t_reset();
    cnt_is("R1", 0, 0); cnt_is("R1", 33, 0); cnt_is("R1", 63, 0);
    chk("R1", "err_ovf", int'(err_ovf), 0);
    chk("R1", "err_unf", int'(err_unf), 0);
  endtask

  task automatic t_inc();
    start_vld = 1'b1; start_idx = 6'd5; tick();
    cnt_is("R2", 5, 1);
    mcmd_vld = 1'b1; mcmd_idx = 6'd5; tick();
    mcmd_vld = 1'b1; mcmd_idx = 6'd5; tick();
    cnt_is("R3", 5, 3);
  endtask

  task automatic t_dec();
    mrsp_vld = 1'b1; mrsp_idx = 6'd5; tick();
    cnt_is("R4", 5, 2);
    ack_vld = 1'b1; ack_idx = 6'd5; tick();
    cnt_is("R4", 5, 1);
    ack_vld = 1'b1; ack_idx = 6'd5; tick();
    cnt_is("R4", 5, 0);
  endtask

  task automatic t_noforward();
    @(negedge clk);
    start_vld = 1'b1; start_idx = 6'd9; rd_idx = 6'd9; #1;
    chk("R5", "no same-cycle forward", int'(rd_count), 0);
    chk("R5", "pending before edge", int'(rd_pending), 0);
    tick();
    cnt_is("R5", 9, 1);
    ack_vld = 1'b1; ack_idx = 6'd9; tick();
  endtask

  task automatic t_combine();
    start_vld = 1'b1; start_idx = 6'd12; mcmd_vld = 1'b1; mcmd_idx = 6'd12; tick();
    cnt_is("R6", 12, 2);
    start_vld = 1'b1; start_idx = 6'd12; mcmd_vld = 1'b1; mcmd_idx = 6'd12;
    mrsp_vld = 1'b1; mrsp_idx = 6'd12; ack_vld = 1'b1; ack_idx = 6'd12; tick();
    cnt_is("R6", 12, 2);
    mrsp_vld = 1'b1; mrsp_idx = 6'd12; ack_vld = 1'b1; ack_idx = 6'd12; tick();
    cnt_is("R6", 12, 0);
    start_vld = 1'b1; start_idx = 6'd12; ack_vld = 1'b1; ack_idx = 6'd12; tick();
    cnt_is("R6", 12, 0);
    chk("R6", "no underflow on net zero", int'(err_unf), 0);
  endtask

  task automatic t_indep();
    load(40, 3);
    start_vld = 1'b1; start_idx = 6'd0; mcmd_vld = 1'b1; mcmd_idx = 6'd63;
    ack_vld = 1'b1; ack_idx = 6'd40; tick();
    cnt_is("R12", 0, 1); cnt_is("R12", 63, 1); cnt_is("R12", 40, 2);
    cnt_is("R12", 1, 0); cnt_is("R12", 62, 0); cnt_is("R12", 41, 0);
  endtask

  task automatic t_write();
    load(20, 7);
    cnt_is("R9", 20, 7);
    wr_vld = 1'b1; wr_idx = 6'd20; wr_data = 4'd4;
    ack_vld = 1'b1; ack_idx = 6'd20; start_vld = 1'b1; start_idx = 6'd20; tick();
    cnt_is("R11", 20, 4);
    load(21, 0);
    wr_vld = 1'b1; wr_idx = 6'd21; wr_data = 4'd2; ack_vld = 1'b1; ack_idx = 6'd21; tick();
    cnt_is("R11", 21, 2);
    chk("R11", "no error from dropped dec", int'(err_unf), 0);
  endtask

  task automatic t_clear();
    clr_vld = 1'b1; clr_idx = 6'd20; tick();
    cnt_is("R10", 20, 0);
    load(22, 15);
    clr_vld = 1'b1; clr_idx = 6'd22; wr_vld = 1'b1; wr_idx = 6'd22; wr_data = 4'd9;
    start_vld = 1'b1; start_idx = 6'd22; tick();
    cnt_is("R11", 22, 0);
    chk("R11", "no error from dropped inc", int'(err_ovf), 0);
    clr_vld = 1'b1; clr_idx = 6'd23; mrsp_vld = 1'b1; mrsp_idx = 6'd23; tick();
    cnt_is("R11", 23, 0);
    chk("R11", "no error from dropped dec", int'(err_unf), 0);
  endtask

  task automatic t_floor();
    ack_vld = 1'b1; ack_idx = 6'd30; tick();
    cnt_is("R8", 30, 0);
    chk("R8", "err_unf set", int'(err_unf), 1);
    chk("R8", "err_ovf clear", int'(err_ovf), 0);
    start_vld = 1'b1; start_idx = 6'd30; tick();
    chk("R8", "err_unf sticky", int'(err_unf), 1);
    cnt_is("R8", 30, 1);
  endtask

  task automatic t_sat();
    load(31, 14);
    start_vld = 1'b1; start_idx = 6'd31; mcmd_vld = 1'b1; mcmd_idx = 6'd31; tick();
    cnt_is("R7", 31, 15);
    chk("R7", "err_ovf set", int'(err_ovf), 1);
    ack_vld = 1'b1; ack_idx = 6'd31; tick();
    cnt_is("R7", 31, 14);
    chk("R7", "err_ovf sticky", int'(err_ovf), 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    idle(); rd_idx = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1; #1;
    t_reset();
    t_inc();
    t_dec();
    t_noforward();
    t_combine();
    t_indep();
    t_write();
    t_clear();
    t_floor();
    t_sat();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule